// File: doc/BRIEF.md
# NAND Command Engine Interrupt and Status Register

This block is the interrupt and status register of a NAND flash command engine. It collects three interrupt sources: a write error found by a read-status command, completion of a command, and the moment the whole datapath comes to rest (command finished while the residue, ECC and DMA engines are all idle). It also shows the live busy levels of the command sequencer, residue engine, ECC engine and DMA engine. Software enables each source on its own and acknowledges a flag by writing 1 to that source's clear bit. The clear bits act only on the write and never hold a value.

The engines deliver single-cycle event pulses and level busy signals. The block presents one 16-bit register through a write strobe with write data and a combinational read path. It drives a single interrupt line, which is the OR of every flag gated by its enable. A flag still latches while its enable is 0, so enabling it later raises the line at once.

Top module: `flash_irq_stat_reg`

## Requirements
- R1: After reset every flag, enable and status bit is 0, so the read value shows only the live busy bits and `irq_o` is 0.
- R2: A `rdstat_done_i` pulse with `rdstat_err_i` high sets the write-error flag (bit 0). The write-error status bit (bit 3) takes the value of `rdstat_err_i` on each `rdstat_done_i` pulse, so it reflects the most recent read-status command.
- R3: A write with bit 11 at 1 clears both the write-error flag (bit 0) and the write-error status bit (bit 3) on the next clock edge.
- R4: A `cmd_done_i` pulse sets the command-done flag (bit 1). The flag holds until a write with bit 12 at 1 clears it.
- R5: The idle flag (bit 2) sets once on each entry into the idle condition, one edge after that condition first holds. The idle condition is: command-done flag set while `res_busy_i`, `ecc_busy_i` and `dma_busy_i` are all 0. A write with bit 13 at 1 clears the idle flag. It does not set again while the condition stays true.
- R6: The clear bits 11 to 13 always read 0. Bits 14, 15 and 0 to 7 are unaffected by writes.
- R7: Read bits 4 to 7 follow `seq_busy_i`, `res_busy_i`, `ecc_busy_i` and `dma_busy_i` in the same cycle, in that order.
- R8: Bits 8, 9 and 10 are read/write enables for the write-error, command-done and idle flags. `irq_o` is the OR of each flag ANDed with its enable. Flags latch regardless of their enable.
- R9: When a set event and a clear write reach the same flag in the same cycle, the flag ends up set. The same holds for the status bit when the read-status result is an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data |
| rdstat_done_i | input | 1 | Read-status command finished (pulse) |
| rdstat_err_i | input | 1 | Error result of that read-status command |
| cmd_done_i | input | 1 | Command processing finished (pulse) |
| seq_busy_i | input | 1 | Command sequencer busy level |
| res_busy_i | input | 1 | Residue engine busy level |
| ecc_busy_i | input | 1 | ECC engine busy level |
| dma_busy_i | input | 1 | DMA engine busy level |
| irq_o | output | 1 | Combined interrupt |

## Verification
Two functions can collide in one cycle: an engine event that sets a flag, and a software write that clears the same flag. The bench provokes this directly for the command-done and write-error flags. It also lets random clear writes coincide with random event pulses and entries into idle over thousands of cycles. A bench model predicts each flag with set-over-clear priority, and the read value is compared field by field after every edge.

// File: rtl/flash_irq_pkg.sv
package flash_irq_pkg;
  localparam int REG_W    = 16;
  localparam int N_IRQ    = 3;
  localparam int N_BUSY   = 4;
  localparam int N_ENG    = 3;
  // field positions in the register
  localparam int FLG_LSB  = 0;
  localparam int STS_BIT  = FLG_LSB + N_IRQ;
  localparam int BUSY_LSB = STS_BIT + 1;
  localparam int EN_LSB   = BUSY_LSB + N_BUSY;
  localparam int CLR_LSB  = EN_LSB + N_IRQ;
  // interrupt indices
  localparam int IRQ_WERR = 0;
  localparam int IRQ_DONE = 1;
  localparam int IRQ_IDLE = 2;
endpackage

// File: rtl/irq_flag_cell.sv
module irq_flag_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  // R9
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o);
  // R3
  clr_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !flag_o);
  // R4
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !clr_i) |=> $stable(flag_o));
endmodule

// File: rtl/werr_status_cell.sv
module werr_status_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic err_i,
  input  logic clr_i,
  output logic sts_o
);
  logic sts_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sts_q <= 1'b0;
    else if (load_i) sts_q <= err_i;
    else if (clr_i)  sts_q <= 1'b0;
  end

  assign sts_o = sts_q;

  // R2
  sts_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (sts_o == $past(err_i)));
  // R3
  sts_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !load_i) |=> !sts_o);
endmodule

// File: rtl/idle_edge_det.sv
module idle_edge_det #(
  parameter int N_ENG = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             done_flag_i,
  input  logic [N_ENG-1:0] eng_busy_i,
  output logic             rise_o
);
  logic cond, prev_q;

  assign cond = done_flag_i && !(|eng_busy_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= cond;
  end

  assign rise_o = cond && !prev_q;

  // R5
  single_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
  // R5
  rise_needs_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |-> (done_flag_i && eng_busy_i == '0));
endmodule

// File: rtl/flash_irq_stat_reg.sv
module flash_irq_stat_reg
  import flash_irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  input  logic             rdstat_done_i,
  input  logic             rdstat_err_i,
  input  logic             cmd_done_i,
  input  logic             seq_busy_i,
  input  logic             res_busy_i,
  input  logic             ecc_busy_i,
  input  logic             dma_busy_i,
  output logic             irq_o
);
  logic [N_IRQ-1:0]  clr_vec, set_vec, flag, en_q;
  logic [N_BUSY-1:0] busy;
  logic              sts, idle_rise, wdata_unused;

  assign wdata_unused = ^{reg_wdata_i[EN_LSB-1:0], reg_wdata_i[REG_W-1:CLR_LSB+N_IRQ]};

  assign clr_vec = reg_we_i ? reg_wdata_i[CLR_LSB +: N_IRQ] : '0;
  assign busy    = {dma_busy_i, ecc_busy_i, res_busy_i, seq_busy_i};

  assign set_vec[IRQ_WERR] = rdstat_done_i && rdstat_err_i;
  assign set_vec[IRQ_DONE] = cmd_done_i;
  assign set_vec[IRQ_IDLE] = idle_rise;

  for (genvar i = 0; i < N_IRQ; i++) begin : g_flag
    irq_flag_cell u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set_vec[i]),
      .clr_i  (clr_vec[i]),
      .flag_o (flag[i])
    );
  end

  werr_status_cell u_sts (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (rdstat_done_i),
    .err_i  (rdstat_err_i),
    .clr_i  (clr_vec[IRQ_WERR]),
    .sts_o  (sts)
  );

  idle_edge_det #(.N_ENG(N_ENG)) u_idle (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .done_flag_i (flag[IRQ_DONE]),
    .eng_busy_i  ({dma_busy_i, ecc_busy_i, res_busy_i}),
    .rise_o      (idle_rise)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       en_q <= '0;
    else if (reg_we_i) en_q <= reg_wdata_i[EN_LSB +: N_IRQ];
  end

  assign irq_o = |(flag & en_q);

  always_comb begin
    reg_rdata_o                     = '0;
    reg_rdata_o[FLG_LSB +: N_IRQ]   = flag;
    reg_rdata_o[STS_BIT]            = sts;
    reg_rdata_o[BUSY_LSB +: N_BUSY] = busy;
    reg_rdata_o[EN_LSB +: N_IRQ]    = en_q;
  end

  // R8
  en_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i |=> (reg_rdata_o[EN_LSB +: N_IRQ] == $past(reg_wdata_i[EN_LSB +: N_IRQ])));
  // R8
  masked_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o[EN_LSB +: N_IRQ] == '0) |-> !irq_o);
  // R6
  clr_reads_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[CLR_LSB +: N_IRQ] == '0);
endmodule

// File: tb/sim_flash_irq_stat_reg.sv
`timescale 1ns/1ps
module sim_flash_irq_stat_reg;
  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        reg_we = 1'b0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic        rd_done = 1'b0, rd_err = 1'b0, cmd_done = 1'b0;
  logic        seq_b = 1'b0, res_b = 1'b0, ecc_b = 1'b0, dma_b = 1'b0;
  logic        irq;
  int          n_chk = 0, n_fail = 0;
  bit          finished = 1'b0;
  logic [2:0]  m_flg = '0, m_en = '0;
  logic        m_sts = 1'b0, m_prev = 1'b0;

  always #2 clk = ~clk;

  flash_irq_stat_reg u0 (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(reg_we), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .rdstat_done_i(rd_done), .rdstat_err_i(rd_err),
    .cmd_done_i(cmd_done), .seq_busy_i(seq_b), .res_busy_i(res_b),
    .ecc_busy_i(ecc_b), .dma_busy_i(dma_b), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic exp_irq(input logic [2:0] f, input logic [2:0] e);
    return |(f & e);
  endfunction

  task automatic check_all();
    check("R2 werr flag", reg_rdata[0], m_flg[0]);
    check("R4 done flag", reg_rdata[1], m_flg[1]);
    check("R5 idle flag", reg_rdata[2], m_flg[2]);
    check("R2 werr status", reg_rdata[3], m_sts);
    check("R7 busy bits", reg_rdata[7:4], {dma_b, ecc_b, res_b, seq_b});
    check("R8 enable bits", reg_rdata[10:8], m_en);
    check("R6 clear and spare bits", reg_rdata[15:11], 5'd0);
    check("R8 irq line", irq, exp_irq(m_flg, m_en));
  endtask

  // busy order: [0]=seq [1]=res [2]=ecc [3]=dma
  task automatic step(input logic we, input logic [15:0] wd, input logic sd,
                      input logic se, input logic cd, input logic [3:0] bz);
    logic [2:0] clr, set;
    logic cond;
    @(negedge clk);
    reg_we = we; reg_wdata = wd; rd_done = sd; rd_err = se; cmd_done = cd;
    {dma_b, ecc_b, res_b, seq_b} = bz;
    @(posedge clk);
    clr  = we ? wd[13:11] : 3'b000;
    cond = m_flg[1] && bz[3:1] == 3'b000;
    set  = {cond && !m_prev, cd, sd && se};
    for (int i = 0; i < 3; i++) m_flg[i] = set[i] | (m_flg[i] & ~clr[i]);
    if (sd)          m_sts = se;
    else if (clr[0]) m_sts = 1'b0;
    if (we) m_en = wd[10:8];
    m_prev = cond;
    #1;
    check_all();
  endtask

  task automatic idle_cycle();
    step(1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 4'h0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    #1;
    check("R1 reset read value", reg_rdata, 16'h0000);
    check("R1 reset irq", irq, 1'b0);
    #6 rst_ni = 1'b1;
    idle_cycle();
    check("R1 after reset", reg_rdata, 16'h0000);

    // R4 / R5: done pulse, idle flag one edge later, once
    step(1'b0, 16'h0, 1'b0, 1'b0, 1'b1, 4'h0);
    check("R4 done set", reg_rdata[1], 1'b1);
    check("R5 idle not yet", reg_rdata[2], 1'b0);
    idle_cycle();
    check("R5 idle set", reg_rdata[2], 1'b1);
    step(1'b1, 16'h2000, 1'b0, 1'b0, 1'b0, 4'h0);
    check("R5 idle cleared", reg_rdata[2], 1'b0);
    for (int i = 0; i < 4; i++) idle_cycle();
    check("R5 no re-fire while idle", reg_rdata[2], 1'b0);
    check("R4 done holds", reg_rdata[1], 1'b1);
    // re-entry after DMA busy
    step(1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 4'h8);
    idle_cycle();
    check("R5 re-entry sets idle", reg_rdata[2], 1'b1);

    // R8: flag latches while disabled, enable raises line
    check("R8 disabled no irq", irq, 1'b0);
    step(1'b1, 16'h0200, 1'b0, 1'b0, 1'b0, 4'h0);
    check("R8 enabled done irq", irq, 1'b1);

    // R9: set and clear on done flag together
    step(1'b1, 16'h1200, 1'b0, 1'b0, 1'b1, 4'h0);
    check("R9 done set wins", reg_rdata[1], 1'b1);

    // R2 / R3 / R9: write error
    step(1'b0, 16'h0, 1'b1, 1'b1, 1'b0, 4'h0);
    check("R2 werr flag set", reg_rdata[0], 1'b1);
    check("R2 status set", reg_rdata[3], 1'b1);
    step(1'b0, 16'h0, 1'b1, 1'b0, 1'b0, 4'h0);
    check("R2 status follows clean result", reg_rdata[3], 1'b0);
    check("R2 werr flag stays", reg_rdata[0], 1'b1);
    step(1'b1, 16'h0800, 1'b1, 1'b1, 1'b0, 4'h0);
    check("R9 werr set wins", reg_rdata[0], 1'b1);
    check("R9 status set wins", reg_rdata[3], 1'b1);
    step(1'b1, 16'h0800, 1'b0, 1'b0, 1'b0, 4'h0);
    check("R3 werr flag cleared", reg_rdata[0], 1'b0);
    check("R3 status cleared", reg_rdata[3], 1'b0);

    // R6: write all ones; read-only bits untouched
    step(1'b1, 16'hC0FF, 1'b0, 1'b0, 1'b0, 4'hF);
    check("R6 spare bits zero", reg_rdata[15:11], 5'd0);
    check("R7 all busy", reg_rdata[7:4], 4'hF);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic we;
      logic [15:0] wd;
      we = ($urandom % 5) == 0;
      wd = 16'($urandom);
      step(we, wd, ($urandom % 6) == 0, $urandom % 2 == 1,
           ($urandom % 8) == 0, 4'($urandom % 16) & {4{($urandom % 3) == 0}});
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule